// File: doc/BRIEF.md
# Field-Delay Memory Write Port Controller

This block drives the write side of a deep serial field-delay memory. It takes one write clock, a write reset, a write-enable that gates pointer movement, an input-enable that masks a single write, a one-bit serial start-address input and a 24-bit data word. It produces a registered write strobe, write address and write data for a plain single-port array. All three come out through a fixed four-stage pipeline, so every control and data input reaches the array four clocks after it is sampled.

A write reset starts a serial load of a 21-bit start address, least significant bit first. The load takes the reset edge and the 20 edges after it. A settle interval follows, and then the pointer moves under the enables. Write-enable low freezes the pointer. Input-enable low with write-enable high skips the location but still advances the pointer, so a window inside a field can be rewritten while the rest stays intact. The block watches the handshake rules around a reset and keeps a sticky error flag when they are broken. A status output shows when no start address is held.

Top module: `wr_port_ctrl`

## Requirements
- R1: After rst_ni, mem_we_o is 0, not_init_o is 1 and proto_err_o is 0. Until a start address has been loaded, wr_en_i and in_en_i high produce no write strobe.
- R2: On the edge where wr_rst_i is sampled 1, addr_ser_i is taken as address bit 0. Bits 1 to 20 follow on the next 20 edges. The pointer is then set to that 21-bit value modulo DEPTH. not_init_o stays 1 from the reset edge through the load and drops to 0 after the edge that takes bit 20.
- R3: In the run state, wr_en_i=1 and in_en_i=1 produce one strobe that carries the current pointer and data_i. The pointer then advances by one.
- R4: In the run state, wr_en_i=1 with in_en_i=0 produces no strobe, but the pointer still advances. The skipped location keeps its old contents.
- R5: wr_en_i=0 produces no strobe and leaves the pointer unchanged.
- R6: Inputs sampled at edge k appear on mem_we_o, mem_addr_o and mem_data_o after edge k+3. An array clocked on the same edge commits the word at edge k+4.
- R7: The pointer stays below DEPTH and wraps from DEPTH-1 to 0.
- R8: No write happens during the load and for SETTLE_CYC cycles after it. wr_en_i sampled 1 in that window sets proto_err_o.
- R9: proto_err_o is set if wr_rst_i is sampled 1 when fewer than MIN_LOW consecutive edges with wr_en_i=0 came before it, or when wr_en_i=1 on the reset edge itself.
- R10: proto_err_o is set if the first raise of wr_en_i after a load lasts only one cycle.
- R11: proto_err_o is set if wr_rst_i arrives after a completed load that has seen fewer than MIN_ACTIVE cycles with both enables high.
- R12: proto_err_o stays set until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_rst_i | input | 1 | Write reset; starts the serial address load |
| wr_en_i | input | 1 | Write-enable; 0 freezes the pointer |
| in_en_i | input | 1 | Input-enable; 0 masks the write, the pointer still moves |
| addr_ser_i | input | 1 | Serial start address, LSB first |
| data_i | input | DW (24) | Write data |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW | Array write address |
| mem_data_o | output | DW (24) | Array write data |
| not_init_o | output | 1 | No start address held (before first load, or loading) |
| proto_err_o | output | 1 | Sticky handshake violation flag |

## Verification
A wrong pointer appears four clocks later as a wrong mem_addr_o on the first strobe after the fault. A skipped advance or a missing wrap shifts every following address by one, so a single vector run with a start address near the top of a small array exposes it. A bad serial load puts the first strobe at the wrong location. A faulty rule monitor shows as a proto_err_o value that disagrees with the expected one on the cycle after the violating edge.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int unsigned LAT      = 4;   // fixed write control latency
  localparam int unsigned SER_BITS = 21;  // serial start address length

  typedef enum logic [1:0] {
    ST_UNINIT,
    ST_LOAD,
    ST_SETTLE,
    ST_RUN
  } wrp_state_e;
endpackage

// File: rtl/wrp_seq.sv
module wrp_seq
  import wrp_pkg::*;
#(
  parameter int unsigned DEPTH      = 1114112,
  parameter int unsigned SETTLE_CYC = 400,
  parameter int unsigned AW         = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rst_i,
  input  logic          addr_ser_i,
  output wrp_state_e    state_o,
  output logic          load_done_o,
  output logic [AW-1:0] load_addr_o
);
  localparam int unsigned BCW = $clog2(SER_BITS);
  localparam int unsigned SCW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  wrp_state_e          state_q;
  logic [BCW-1:0]      bit_cnt_q;
  logic [SCW-1:0]      settle_cnt_q;
  logic [SER_BITS-1:0] shreg_q, shreg_nxt;
  logic                settle_end;

  assign shreg_nxt   = {addr_ser_i, shreg_q[SER_BITS-1:1]};
  assign load_done_o = (state_q == ST_LOAD) && !wr_rst_i &&
                       (32'(bit_cnt_q) == SER_BITS - 1);
  assign load_addr_o = AW'(32'(shreg_nxt) % DEPTH);
  assign state_o     = state_q;

  generate
    if (SETTLE_CYC == 0) begin : g_no_settle
      assign settle_end = 1'b1;
    end else begin : g_settle
      assign settle_end = (32'(settle_cnt_q) == SETTLE_CYC - 1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_UNINIT;
      bit_cnt_q    <= '0;
      settle_cnt_q <= '0;
      shreg_q      <= '0;
    end else if (wr_rst_i) begin
      state_q   <= ST_LOAD;
      bit_cnt_q <= BCW'(1);
      shreg_q   <= shreg_nxt;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          shreg_q   <= shreg_nxt;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (load_done_o) begin
            state_q      <= (SETTLE_CYC == 0) ? ST_RUN : ST_SETTLE;
            settle_cnt_q <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_end) state_q <= ST_RUN;
          else            settle_cnt_q <= settle_cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wrp_ptr.sv
module wrp_ptr #(
  parameter int unsigned DEPTH = 1114112,
  parameter int unsigned AW    = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic          at_top;

  assign at_top = (32'(ptr_q) == DEPTH - 1);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_addr_i;
    else if (adv_i)  ptr_q <= at_top ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/wrp_rules.sv
module wrp_rules
  import wrp_pkg::*;
#(
  parameter int unsigned MIN_LOW    = 4,
  parameter int unsigned MIN_ACTIVE = 231
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_rst_i,
  input  logic       wr_en_i,
  input  logic       in_en_i,
  input  wrp_state_e state_i,
  input  logic       load_done_i,
  output logic       err_o
);
  localparam int unsigned LCW = $clog2(MIN_LOW + 1);
  localparam int unsigned ACW = $clog2(MIN_ACTIVE + 1);

  logic [LCW-1:0] low_cnt_q;
  logic [ACW-1:0] act_cnt_q;
  logic           session_q, arm_q, seen_q, err_q;
  logic           run, bad_reset, early_we, blip, short_sess;

  assign run        = (state_i == ST_RUN) && !wr_rst_i;
  assign bad_reset  = wr_rst_i && ((32'(low_cnt_q) < MIN_LOW) || wr_en_i);
  assign early_we   = !wr_rst_i && wr_en_i &&
                      (state_i == ST_LOAD || state_i == ST_SETTLE);
  assign blip       = run && seen_q && !wr_en_i;
  assign short_sess = wr_rst_i && session_q && (32'(act_cnt_q) < MIN_ACTIVE);
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      act_cnt_q <= '0;
      session_q <= 1'b0;
      arm_q     <= 1'b0;
      seen_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= err_q | bad_reset | early_we | blip | short_sess;
      if (wr_en_i)                         low_cnt_q <= '0;
      else if (32'(low_cnt_q) < MIN_LOW)   low_cnt_q <= low_cnt_q + 1'b1;

      if (wr_rst_i) begin
        session_q <= 1'b0;
        arm_q     <= 1'b0;
        seen_q    <= 1'b0;
      end else if (load_done_i) begin
        session_q <= 1'b1;
        arm_q     <= 1'b1;
        act_cnt_q <= '0;
      end else if (run) begin
        // first raise after a load must last two cycles
        if (arm_q && wr_en_i) begin
          arm_q  <= 1'b0;
          seen_q <= 1'b1;
        end
        if (seen_q) seen_q <= 1'b0;
        if (wr_en_i && in_en_i && (32'(act_cnt_q) < MIN_ACTIVE))
          act_cnt_q <= act_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrp_pipe.sv
module wrp_pipe
  import wrp_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          we_q   [LAT];
  logic [AW-1:0] addr_q [LAT];
  logic [DW-1:0] data_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < LAT; s++) begin
        we_q[s]   <= 1'b0;
        addr_q[s] <= '0;
        data_q[s] <= '0;
      end
    end else begin
      we_q[0]   <= we_i;
      addr_q[0] <= addr_i;
      data_q[0] <= data_i;
      for (int s = 1; s < LAT; s++) begin
        we_q[s]   <= we_q[s-1];
        addr_q[s] <= addr_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  assign we_o   = we_q[LAT-1];
  assign addr_o = addr_q[LAT-1];
  assign data_o = data_q[LAT-1];
endmodule

// File: rtl/wr_port_ctrl.sv
module wr_port_ctrl
  import wrp_pkg::*;
#(
  parameter int unsigned DEPTH      = 1114112,
  parameter int unsigned DW         = 24,
  parameter int unsigned SETTLE_CYC = 400,
  parameter int unsigned MIN_LOW    = 4,
  parameter int unsigned MIN_ACTIVE = 231,
  localparam int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rst_i,
  input  logic          wr_en_i,
  input  logic          in_en_i,
  input  logic          addr_ser_i,
  input  logic [DW-1:0] data_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          not_init_o,
  output logic          proto_err_o
);
  wrp_state_e    state_s;
  logic          load_done_s, run_s, adv_s, write_go_s;
  logic [AW-1:0] load_addr_s, ptr_s;

  wrp_seq #(.DEPTH(DEPTH), .SETTLE_CYC(SETTLE_CYC), .AW(AW)) seq_i (
    .clk_i, .rst_ni, .wr_rst_i, .addr_ser_i,
    .state_o(state_s), .load_done_o(load_done_s), .load_addr_o(load_addr_s)
  );

  assign run_s      = (state_s == ST_RUN);
  assign adv_s      = run_s && wr_en_i && !wr_rst_i;
  assign write_go_s = adv_s && in_en_i;
  assign not_init_o = (state_s == ST_UNINIT) || (state_s == ST_LOAD);

  wrp_ptr #(.DEPTH(DEPTH), .AW(AW)) ptr_i (
    .clk_i, .rst_ni, .load_i(load_done_s), .load_addr_i(load_addr_s),
    .adv_i(adv_s), .ptr_o(ptr_s)
  );

  wrp_rules #(.MIN_LOW(MIN_LOW), .MIN_ACTIVE(MIN_ACTIVE)) rules_i (
    .clk_i, .rst_ni, .wr_rst_i, .wr_en_i, .in_en_i,
    .state_i(state_s), .load_done_i(load_done_s), .err_o(proto_err_o)
  );

  wrp_pipe #(.DW(DW), .AW(AW)) pipe_i (
    .clk_i, .rst_ni, .we_i(write_go_s), .addr_i(ptr_s), .data_i,
    .we_o(mem_we_o), .addr_o(mem_addr_o), .data_o(mem_data_o)
  );
endmodule

// File: rtl/wrp_chk.sv
module wrp_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_rst_i,
  input logic          wr_en_i,
  input logic          in_en_i,
  input logic          mem_we_o,
  input logic          proto_err_o,
  input logic          run_i,
  input logic          write_go_i,
  input logic          load_done_i,
  input logic [AW-1:0] load_addr_i,
  input logic [AW-1:0] ptr_i
);
  // R1 R8
  go_only_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_go_i |-> run_i);
  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
  // R7
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_i) < DEPTH);
  // R5
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_en_i && !wr_rst_i) |=> $stable(ptr_i));
  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wr_en_i && !wr_rst_i) |=>
      (32'(ptr_i) == ((32'($past(ptr_i)) == DEPTH - 1) ? 0 : 32'($past(ptr_i)) + 1)));
  // R2
  load_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_i |=> (ptr_i == $past(load_addr_i)));
  // R6
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(wr_en_i && in_en_i, 4));
endmodule

bind wr_port_ctrl wrp_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk_i, .rst_ni, .wr_rst_i, .wr_en_i, .in_en_i, .mem_we_o, .proto_err_o,
  .run_i(run_s), .write_go_i(write_go_s), .load_done_i(load_done_s),
  .load_addr_i(load_addr_s), .ptr_i(ptr_s)
);

// File: tb/wr_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module wr_port_ctrl_tb_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned SETC  = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_rst_i = 0, wr_en_i = 0, in_en_i = 0, addr_ser_i = 0;
  logic [23:0] data_i = '0;
  logic mem_we_o, not_init_o, proto_err_o;
  logic [3:0] mem_addr_o;
  logic [23:0] mem_data_o;
  logic [23:0] mem [DEPTH];
  logic mem_clr = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  wr_port_ctrl #(.DEPTH(DEPTH), .DW(24), .SETTLE_CYC(SETC), .MIN_LOW(4),
                 .MIN_ACTIVE(8)) dut_i (.*);

  always @(posedge clk_i) begin
    if (mem_clr) for (int i = 0; i < DEPTH; i++) mem[i] <= 24'h5A5A00 | 24'(i);
    else if (mem_we_o) mem[mem_addr_o] <= mem_data_o;
  end

  typedef struct packed {
    logic we; logic ie; logic [23:0] d; logic xwe; logic [3:0] xa;
  } vec_t;

  // start address 13 (loaded value 0x1000D modulo 16)
  localparam vec_t VEC [20] = '{
    '{1,1,24'hC00000,1,4'd13}, '{1,1,24'hC00001,1,4'd14},
    '{1,0,24'hC00002,0,4'd0 }, '{0,1,24'hC00003,0,4'd0 },
    '{0,0,24'hC00004,0,4'd0 }, '{1,1,24'hC00005,1,4'd0 },
    '{1,1,24'hC00006,1,4'd1 }, '{1,0,24'hC00007,0,4'd0 },
    '{1,1,24'hC00008,1,4'd3 }, '{1,1,24'hC00009,1,4'd4 },
    '{0,0,24'hC0000A,0,4'd0 }, '{1,1,24'hC0000B,1,4'd5 },
    '{1,1,24'hC0000C,1,4'd6 }, '{1,1,24'hC0000D,1,4'd7 },
    '{1,1,24'hC0000E,1,4'd8 }, '{0,1,24'hC0000F,0,4'd0 },
    '{0,0,24'h0,0,4'd0}, '{0,0,24'h0,0,4'd0},
    '{0,0,24'h0,0,4'd0}, '{0,0,24'h0,0,4'd0}
  };

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; wr_rst_i = 0; wr_en_i = 0; in_en_i = 0; addr_ser_i = 0;
    repeat (2) tick();
    rst_ni = 1; tick();
  endtask

  task automatic load(logic [20:0] a, bit chk_ni);
    for (int b = 0; b < 21; b++) begin
      wr_rst_i = (b == 0); addr_ser_i = a[b];
      if (chk_ni && b == 20) chk("R2 not_init during load", 32'(not_init_o), 1);
      tick();
    end
    wr_rst_i = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    @(negedge clk_i);
    mem_clr = 1; tick(); mem_clr = 0;
    do_reset();
    chk("R1 we after reset", 32'(mem_we_o), 0);
    chk("R1 not_init after reset", 32'(not_init_o), 1);
    chk("R1 err after reset", 32'(proto_err_o), 0);
    // R1: writes before any load are dropped
    wr_en_i = 1; in_en_i = 1; tick(); tick();
    wr_en_i = 0; in_en_i = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R1 no strobe uninit", 32'(mem_we_o), 0);
      tick();
    end
    load(21'h1000D, 1);
    chk("R2 not_init after load", 32'(not_init_o), 0);
    repeat (SETC) tick();
    // table run: outputs lag by four edges (R6)
    for (int i = 0; i < 20; i++) begin
      if (i >= 4) begin
        chk(VEC[i-4].xwe ? "R3 R6 strobe" : (VEC[i-4].we ? "R4 masked" : "R5 held"),
            32'(mem_we_o), 32'(VEC[i-4].xwe));
        if (VEC[i-4].xwe) begin
          chk("R3 R7 addr", 32'(mem_addr_o), 32'(VEC[i-4].xa));
          chk("R3 R6 data", 32'(mem_data_o), 32'(VEC[i-4].d));
        end
      end
      wr_en_i = VEC[i].we; in_en_i = VEC[i].ie; data_i = VEC[i].d;
      tick();
    end
    chk("R6 committed", 32'(mem[13]), 32'h00C00000);
    chk("R4 skipped loc 15", 32'(mem[15]), 32'h005A5A0F);
    chk("R4 skipped loc 2", 32'(mem[2]), 32'h005A5A02);
    chk("R7 wrapped to 0", 32'(mem[0]), 32'h00C00005);
    chk("R11 R9 clean session", 32'(proto_err_o), 0);
    // reload with a new start address
    load(21'd5, 0);
    chk("R9 R11 clean reload", 32'(proto_err_o), 0);
    repeat (SETC) tick();
    wr_en_i = 1; in_en_i = 1; data_i = 24'hABCDEF; tick();
    data_i = 24'h123456; tick();
    wr_en_i = 0; tick(); tick();
    chk("R2 first write addr", 32'(mem_addr_o), 5);
    chk("R2 first write data", 32'(mem_data_o), 32'h00ABCDEF);
    tick();
    chk("R3 second write addr", 32'(mem_addr_o), 6);
    chk("R10 two-cycle raise ok", 32'(proto_err_o), 0);

    // R8: enable during settle
    do_reset(); repeat (4) tick();
    load(21'd3, 0);
    wr_en_i = 1; in_en_i = 1; tick(); wr_en_i = 0;
    chk("R8 early enable flagged", 32'(proto_err_o), 1);
    for (int k = 0; k < 5; k++) begin
      chk("R8 no strobe in settle", 32'(mem_we_o), 0);
      tick();
    end
    repeat (10) tick();
    chk("R12 error sticky", 32'(proto_err_o), 1);
    do_reset();
    chk("R12 cleared by rst_ni", 32'(proto_err_o), 0);

    // R9: too few low cycles before reset
    tick(); tick();
    load(21'd1, 0);
    chk("R9 short low before reset", 32'(proto_err_o), 1);

    // R10: one-cycle first raise
    do_reset(); repeat (4) tick();
    load(21'd2, 0); repeat (SETC) tick();
    wr_en_i = 1; in_en_i = 1; tick(); wr_en_i = 0;
    chk("R10 no error yet", 32'(proto_err_o), 0);
    tick();
    chk("R10 one-cycle raise", 32'(proto_err_o), 1);

    // R11: session shorter than MIN_ACTIVE
    do_reset(); repeat (4) tick();
    load(21'd4, 0); repeat (SETC) tick();
    wr_en_i = 1; in_en_i = 1; repeat (3) tick();
    wr_en_i = 0; repeat (4) tick();
    chk("R11 before reset", 32'(proto_err_o), 0);
    wr_rst_i = 1; tick(); wr_rst_i = 0;
    chk("R11 short session", 32'(proto_err_o), 1);
    report();
  end
endmodule